// File: doc/BRIEF.md
# Late-Write Synchronous Static RAM

This block is a synthesizable behavioural model of a synchronous static RAM. Its interface needs no idle cycle when the bus changes direction. Commands are captured on the rising clock edge. Each command carries a select, a read/write flag, an address and per-byte write enables. For a write, the data follows the command by a fixed number of edges. Because the data of each command lands in its own bus slot, a stream of reads and writes keeps the data bus busy every cycle.

A static mode input chooses between two read paths. The flow-through path returns read data in the cycle after the command edge. The pipelined path passes it through an output register, so it arrives one cycle later. In pipelined mode a read can come before an earlier write to the same address has been committed. In that case the model forwards the write data into the read, byte by byte.

Each 9-bit byte that is written is checked against a selectable parity polarity. A registered active-low flag reports any mismatch, in the style of an open-drain output. The bus driver is modelled as a data port plus a drive-enable output. The output enable and the sleep input turn the drive off combinationally.

Top module: `lws_sram`

## Requirements
- R1: A command is taken on a rising edge only when clk_en is high, all three selects are high and sleep is low. Any other command is a deselect: it neither reads nor writes.
- R2: In flow-through mode (pipe_mode=0), a read taken at edge E drives its word on dout, with dout_drv high, from just after E until the next edge.
- R3: In pipelined mode (pipe_mode=1), a read taken at edge E drives nothing after E. It drives its word from just after edge E+1 until the next edge.
- R4: Write data is sampled from din at edge E+1 in flow-through mode and at edge E+2 in pipelined mode, where E is the edge that took the write command.
- R5: In either mode, an alternating read/write command stream on consecutive edges fills the data bus every cycle, with no inserted idle slot. Every read returns the current contents.
- R6: Bit i of byte_en enables byte i, which is din[9i+8:9i]. A byte whose enable is low keeps its old contents.
- R7: In pipelined mode, a read issued on the edge after a write to the same address returns the written bytes merged with the old unwritten bytes.
- R8: A deselected bus slot leaves dout_drv low and dout at zero.
- R9: While clk_en is low, no command is taken, no write data is sampled and the outputs do not change.
- R10: out_en low forces dout_drv low and dout to zero at once, without waiting for a clock edge.
- R11: sleep high forces dout_drv low at once. Commands presented while asleep are deselects, and the stored contents are kept.
- R12: With par_even=1 a byte fails when the XOR of its 9 bits is 1. With par_even=0 it fails when that XOR is 0. If any enabled byte fails, par_err_n is low for the cycle after the data-sampling edge. The write is still stored.
- R13: While rst_n is low, dout_drv is low, par_err_n is high and all pending commands are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode | input | 1 | Static read path: 1 pipelined, 0 flow-through |
| clk_en | input | 1 | High to advance; low holds every stage |
| sel_a | input | 1 | Chip select, active high |
| sel_b | input | 1 | Chip select, active high |
| sel_c | input | 1 | Chip select, active high |
| wr | input | 1 | 1 write command, 0 read command |
| byte_en | input | BYTES | Per-byte write enables |
| addr | input | ADDR_W | Word address |
| din | input | 9*BYTES | Late write data |
| par_even | input | 1 | Parity polarity: 1 even, 0 odd |
| out_en | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Asynchronous power-down, active high |
| dout | output | 9*BYTES | Read data, zero when not driven |
| dout_drv | output | 1 | High while the block drives the data bus |
| par_err_n | output | 1 | Registered parity error flag, active low |

## Verification
The bench targets the two slot timings first. If the read latency or the write-data latency is off by one edge, a read/write stream returns a neighbour's data or stores the wrong word, and the back-to-back and basic tests catch both. A pipelined read right behind a partial write to the same address catches missing forwarding, which returns stale bytes, and forwarding that ignores byte enables, which overwrites the unwritten byte. A design that lets holds, deselects or sleep leak through would store data from a frozen cycle, drive the bus in an empty slot or wake with a phantom read. A design that inverts the parity polarity or ignores the byte mask would raise the flag on clean bytes, or miss a bad one.

// File: rtl/lws_pkg.sv
package lws_pkg;

   // Every data byte is nine bits wide.
   localparam int unsigned LANE_W = 9;

   // Returns 1 when a byte fails the selected polarity (1 = even, 0 = odd).
   function automatic logic lane_parity_bad(input logic [LANE_W-1:0] bits,
                                            input logic even_sel);
      return (^bits) ^ ~even_sel;
   endfunction

endpackage

// File: rtl/lws_cmd_stage.sv
module lws_cmd_stage #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned BYTES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              d_valid,
   input  logic              d_write,
   input  logic [ADDR_W-1:0] d_addr,
   input  logic [BYTES-1:0]  d_be,
   output logic              q_valid,
   output logic              q_write,
   output logic [ADDR_W-1:0] q_addr,
   output logic [BYTES-1:0]  q_be
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_write <= 1'b0;
         q_addr  <= '0;
         q_be    <= '0;
      end else if (adv) begin
         q_valid <= d_valid;
         q_write <= d_write;
         q_addr  <= d_addr;
         q_be    <= d_be;
      end
   end

endmodule

// File: rtl/lws_lane.sv
module lws_lane
   import lws_pkg::*;
(
   input  logic [LANE_W-1:0] stored,
   input  logic [LANE_W-1:0] incoming,
   input  logic              use_incoming,
   input  logic              even_sel,
   output logic [LANE_W-1:0] merged,
   output logic              parity_bad
);

   assign merged     = use_incoming ? incoming : stored;
   assign parity_bad = lane_parity_bad(incoming, even_sel);

endmodule

// File: rtl/lws_array.sv
module lws_array
   import lws_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned BYTES  = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wen,
   input  logic [ADDR_W-1:0]         waddr,
   input  logic [BYTES-1:0]          wmask,
   input  logic [BYTES*LANE_W-1:0]   wdata,
   input  logic [ADDR_W-1:0]         raddr,
   output logic [BYTES*LANE_W-1:0]   rdata
);

   localparam int unsigned DEPTH  = 1 << ADDR_W;
   localparam int unsigned DATA_W = BYTES * LANE_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wen) begin
         for (int b = 0; b < BYTES; b++) begin
            if (wmask[b]) cells[waddr][b*LANE_W +: LANE_W] <= wdata[b*LANE_W +: LANE_W];
         end
      end
   end

   assign rdata = cells[raddr];

   // A full-word write is visible on the read port after the edge.
   assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wen && (&wmask)) |=> ((raddr != $past(waddr)) || (rdata == $past(wdata))))
      else $error("full write did not land in the array");

endmodule

// File: rtl/lws_sram.sv
module lws_sram
   import lws_pkg::*;
#(
   parameter int unsigned BYTES  = 2,
   parameter int unsigned ADDR_W = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    pipe_mode,
   input  logic                    clk_en,
   input  logic                    sel_a,
   input  logic                    sel_b,
   input  logic                    sel_c,
   input  logic                    wr,
   input  logic [BYTES-1:0]        byte_en,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [BYTES*LANE_W-1:0] din,
   input  logic                    par_even,
   input  logic                    out_en,
   input  logic                    sleep,
   output logic [BYTES*LANE_W-1:0] dout,
   output logic                    dout_drv,
   output logic                    par_err_n
);

   localparam int unsigned DATA_W = BYTES * LANE_W;
   localparam int unsigned STAGES = 2;

   initial begin
      assert (BYTES == 2 || BYTES == 4) else $error("BYTES must be 2 or 4");
      assert (ADDR_W >= 1 && ADDR_W <= 10) else $error("ADDR_W out of range");
   end

   // Command chain: index 0 is the incoming command, 1 and 2 are the stages.
   logic [STAGES:0]   ch_valid;
   logic [STAGES:0]   ch_write;
   logic [ADDR_W-1:0] ch_addr [STAGES+1];
   logic [BYTES-1:0]  ch_be   [STAGES+1];
   logic              selected;

   assign selected    = sel_a & sel_b & sel_c & ~sleep;
   assign ch_valid[0] = selected;
   assign ch_write[0] = wr;
   assign ch_addr[0]  = addr;
   assign ch_be[0]    = byte_en;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      lws_cmd_stage #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_stage (
         .clk     (clk),
         .rst_n   (rst_n),
         .adv     (clk_en),
         .d_valid (ch_valid[g]),
         .d_write (ch_write[g]),
         .d_addr  (ch_addr[g]),
         .d_be    (ch_be[g]),
         .q_valid (ch_valid[g+1]),
         .q_write (ch_write[g+1]),
         .q_addr  (ch_addr[g+1]),
         .q_be    (ch_be[g+1])
      );
   end

   // Write port: the slot whose data is on din this cycle.
   logic              wcmd_v;
   logic [ADDR_W-1:0] wcmd_addr;
   logic [BYTES-1:0]  wcmd_be;
   logic              wen;

   always_comb begin
      if (pipe_mode) begin
         wcmd_v    = ch_valid[2] & ch_write[2];
         wcmd_addr = ch_addr[2];
         wcmd_be   = ch_be[2];
      end else begin
         wcmd_v    = ch_valid[1] & ch_write[1];
         wcmd_addr = ch_addr[1];
         wcmd_be   = ch_be[1];
      end
   end

   assign wen = clk_en & wcmd_v;

   logic [DATA_W-1:0] rdata;

   lws_array #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_array (
      .clk   (clk),
      .rst_n (rst_n),
      .wen   (wen),
      .waddr (wcmd_addr),
      .wmask (wcmd_be),
      .wdata (din),
      .raddr (ch_addr[1]),
      .rdata (rdata)
   );

   // Per-byte forwarding merge and parity check.
   logic              fwd_hit;
   logic [DATA_W-1:0] fwd_word;
   logic [BYTES-1:0]  lane_bad;

   assign fwd_hit = pipe_mode & ch_valid[2] & ch_write[2] & (ch_addr[2] == ch_addr[1]);

   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      lws_lane u_lane (
         .stored       (rdata[b*LANE_W +: LANE_W]),
         .incoming     (din[b*LANE_W +: LANE_W]),
         .use_incoming (fwd_hit & ch_be[2][b]),
         .even_sel     (par_even),
         .merged       (fwd_word[b*LANE_W +: LANE_W]),
         .parity_bad   (lane_bad[b])
      );
   end

   // Pipelined output register and the parity flag.
   logic [DATA_W-1:0] q_reg;
   logic              q_vld;
   logic              s1_read;

   assign s1_read = ch_valid[1] & ~ch_write[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_reg     <= '0;
         q_vld     <= 1'b0;
         par_err_n <= 1'b1;
      end else if (clk_en) begin
         q_vld     <= s1_read;
         if (s1_read) q_reg <= fwd_word;
         par_err_n <= ~(wcmd_v & (|(lane_bad & wcmd_be)));
      end
   end

   // Bus slot selection and asynchronous drive gating.
   logic              slot_rd;
   logic [DATA_W-1:0] slot_data;

   assign slot_rd   = pipe_mode ? q_vld : s1_read;
   assign slot_data = pipe_mode ? q_reg : rdata;
   assign dout_drv  = slot_rd & out_en & ~sleep;
   assign dout      = dout_drv ? slot_data : '0;

   assert_pipe_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && s1_read) |=> q_vld)
      else $error("pipelined read slot lost");

   assert_flow_desel_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && !pipe_mode && !selected) |=> (pipe_mode || !dout_drv))
      else $error("deselected slot drove the bus");

   assert_sleep_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && sleep) |=> !ch_valid[1])
      else $error("command taken while asleep");

   assert_perr_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(par_err_n) |-> $past(wcmd_v && clk_en))
      else $error("parity flag without a write sample");

endmodule

// File: tb/lws_sram_test.sv
module lws_sram_test;

   localparam int BYTES = 2;
   localparam int AW    = 4;
   localparam int DW    = 18;

   logic          clk = 1'b0;
   logic          rst_n, pipe_mode, clk_en, sel_a, sel_b, sel_c, wr;
   logic [BYTES-1:0] byte_en;
   logic [AW-1:0] addr;
   logic [DW-1:0] din;
   logic          par_even, out_en, sleep;
   logic [DW-1:0] dout;
   logic          dout_drv, par_err_n;

   int n_vec = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   lws_sram #(.BYTES(BYTES), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .clk_en(clk_en),
      .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .wr(wr), .byte_en(byte_en),
      .addr(addr), .din(din), .par_even(par_even), .out_en(out_en), .sleep(sleep),
      .dout(dout), .dout_drv(dout_drv), .par_err_n(par_err_n)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One clocked slot: drive at the falling edge, return at the next falling edge.
   task automatic step(input logic v, input logic w, input logic [AW-1:0] a,
                       input logic [BYTES-1:0] be, input logic [DW-1:0] d);
      clk_en = 1'b1; sel_a = v; wr = w; addr = a; byte_en = be; din = d;
      @(posedge clk); @(negedge clk);
   endtask

   task automatic hold_slot(input logic [DW-1:0] d);
      clk_en = 1'b0; sel_a = 1'b1; wr = 1'b1; addr = 4'd8; byte_en = '1; din = d;
      @(posedge clk); @(negedge clk);
      clk_en = 1'b1;
   endtask

   task automatic idle(input logic [DW-1:0] d);
      step(1'b0, 1'b0, '0, '0, d);
   endtask

   task automatic t_reset;
      chk("R13 drive in reset", {17'd0, dout_drv}, 18'd0);
      chk("R13 parity flag in reset", {17'd0, par_err_n}, 18'd1);
   endtask

   task automatic t_flow_basic;
      pipe_mode = 1'b0; idle('0); idle('0);
      step(1, 1, 4'd3, '1, '0);
      chk("R2 write slot not driven", {17'd0, dout_drv}, 18'd0);
      step(1, 0, 4'd3, '1, 18'h2A5C3);
      chk("R2 flow read drive", {17'd0, dout_drv}, 18'd1);
      chk("R4 flow read data", dout, 18'h2A5C3);
      idle('0);
   endtask

   task automatic t_pipe_basic;
      pipe_mode = 1'b1; idle('0); idle('0);
      step(1, 1, 4'd5, '1, '0);
      idle(18'h3FFFF);
      idle(18'h1B2C4);
      step(1, 0, 4'd5, '1, '0);
      chk("R3 pipelined read not yet driven", {17'd0, dout_drv}, 18'd0);
      idle('0);
      chk("R3 pipelined read drive", {17'd0, dout_drv}, 18'd1);
      chk("R4 pipelined data", dout, 18'h1B2C4);
      idle('0);
   endtask

   task automatic t_b2b_flow;
      pipe_mode = 1'b0; idle('0);
      step(1, 1, 4'd1, '1, '0);
      step(1, 1, 4'd3, '1, 18'h00111);
      step(1, 1, 4'd5, '1, 18'h00333);
      idle(18'h00555);
      step(1, 0, 4'd1, '1, '0);        chk("R5 flow QA", dout, 18'h00111);
      step(1, 1, 4'd2, '1, '0);        chk("R5 flow DB slot", {17'd0, dout_drv}, 18'd0);
      step(1, 0, 4'd3, '1, 18'h12222); chk("R5 flow QC", dout, 18'h00333);
      step(1, 1, 4'd4, '1, '0);        chk("R5 flow DD slot", {17'd0, dout_drv}, 18'd0);
      step(1, 0, 4'd5, '1, 18'h14444); chk("R5 flow QE", dout, 18'h00555);
      step(1, 0, 4'd2, '1, '0);        chk("R5 flow stored DB", dout, 18'h12222);
      step(1, 0, 4'd4, '1, '0);        chk("R5 flow stored DD", dout, 18'h14444);
      idle('0);
   endtask

   task automatic t_b2b_pipe;
      pipe_mode = 1'b1; idle('0); idle('0);
      step(1, 1, 4'd9, '1, '0);
      step(1, 1, 4'd10, '1, '0);
      step(1, 1, 4'd11, '1, 18'h00999);
      idle(18'h00AAA);
      idle(18'h00BBB);
      step(1, 0, 4'd9, '1, '0);
      step(1, 1, 4'd12, '1, '0);         chk("R5 pipe QA", dout, 18'h00999);
      step(1, 0, 4'd10, '1, '0);         chk("R5 pipe DB slot", {17'd0, dout_drv}, 18'd0);
      step(1, 1, 4'd13, '1, 18'h1CCCC);  chk("R5 pipe QC", dout, 18'h00AAA);
      step(1, 0, 4'd11, '1, '0);         chk("R5 pipe DD slot", {17'd0, dout_drv}, 18'd0);
      idle(18'h1DDDD);                   chk("R5 pipe QE", dout, 18'h00BBB);
      step(1, 0, 4'd12, '1, '0);
      idle('0);                          chk("R5 pipe stored DB", dout, 18'h1CCCC);
      step(1, 0, 4'd13, '1, '0);
      idle('0);                          chk("R5 pipe stored DD", dout, 18'h1DDDD);
   endtask

   task automatic t_forward;
      pipe_mode = 1'b1; idle('0);
      step(1, 1, 4'd7, '1, '0);
      idle('0);
      idle(18'h11111);
      step(1, 1, 4'd7, 2'b10, '0);
      step(1, 0, 4'd7, '1, '0);
      idle(18'h2AB55);
      chk("R7 forwarded merge", dout, 18'h2AB11);
      idle('0);
   endtask

   task automatic t_bytes;
      pipe_mode = 1'b0; idle('0); idle('0);
      step(1, 1, 4'd6, '1, '0);
      step(1, 1, 4'd6, 2'b01, 18'h3FFFF);
      step(1, 0, 4'd6, '1, 18'h00012);
      chk("R6 masked byte kept", dout, 18'h3FE12);
      idle('0);
   endtask

   task automatic t_deselect;
      pipe_mode = 1'b0;
      sel_b = 1'b0;
      step(1, 0, 4'd1, '1, '0);
      sel_b = 1'b1;
      chk("R8 deselect drive", {17'd0, dout_drv}, 18'd0);
      chk("R8 deselect data", dout, 18'd0);
      sel_c = 1'b0;
      step(1, 1, 4'd1, '1, '0);
      sel_c = 1'b1;
      idle(18'h3BAD0);
      step(1, 0, 4'd1, '1, '0);
      chk("R1 deselected write ignored", dout, 18'h00111);
      idle('0);
   endtask

   task automatic t_hold;
      pipe_mode = 1'b0;
      step(1, 1, 4'd8, '1, '0);
      hold_slot(18'h3BAD1);
      idle(18'h0C0DE);
      step(1, 0, 4'd8, '1, '0);
      chk("R9 held cycle sampled no data", dout, 18'h0C0DE);
      hold_slot(18'h3BAD2);
      chk("R9 output frozen drive", {17'd0, dout_drv}, 18'd1);
      chk("R9 output frozen data", dout, 18'h0C0DE);
      idle('0);
      step(1, 0, 4'd8, '1, '0);
      chk("R9 held command not taken", dout, 18'h0C0DE);
      idle('0);
   endtask

   task automatic t_oe;
      pipe_mode = 1'b0;
      step(1, 0, 4'd8, '1, '0);
      out_en = 1'b0; #1;
      chk("R10 drive off at once", {17'd0, dout_drv}, 18'd0);
      chk("R10 data zero", dout, 18'd0);
      out_en = 1'b1; #1;
      chk("R10 drive back", {17'd0, dout_drv}, 18'd1);
      idle('0);
   endtask

   task automatic t_sleep;
      pipe_mode = 1'b0;
      step(1, 0, 4'd8, '1, '0);
      sleep = 1'b1; #1;
      chk("R11 sleep drive off", {17'd0, dout_drv}, 18'd0);
      step(1, 0, 4'd8, '1, '0);
      sleep = 1'b0; #1;
      chk("R11 read while asleep dropped", {17'd0, dout_drv}, 18'd0);
      step(1, 0, 4'd8, '1, '0);
      chk("R11 contents kept", dout, 18'h0C0DE);
      idle('0);
   endtask

   task automatic t_parity;
      pipe_mode = 1'b0; par_even = 1'b1;
      step(1, 1, 4'd4, '1, '0);
      idle({9'h003, 9'h001});
      chk("R12 even polarity error", {17'd0, par_err_n}, 18'd0);
      idle('0);
      chk("R12 flag lasts one cycle", {17'd0, par_err_n}, 18'd1);
      par_even = 1'b0;
      step(1, 1, 4'd4, '1, '0);
      idle({9'h007, 9'h001});
      chk("R12 odd polarity clean", {17'd0, par_err_n}, 18'd1);
      step(1, 1, 4'd4, 2'b01, '0);
      idle({9'h003, 9'h001});
      chk("R12 masked byte not checked", {17'd0, par_err_n}, 18'd1);
      step(1, 1, 4'd4, 2'b10, '0);
      idle({9'h003, 9'h001});
      chk("R12 odd polarity error", {17'd0, par_err_n}, 18'd0);
      step(1, 0, 4'd4, '1, '0);
      chk("R12 failing write stored", dout, 18'h00601);
      par_even = 1'b1;
      idle('0);
   endtask

   initial begin
      #2_000_000;
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; pipe_mode = 1'b0; clk_en = 1'b1;
      sel_a = 1'b0; sel_b = 1'b1; sel_c = 1'b1; wr = 1'b0;
      byte_en = '0; addr = '0; din = '0;
      par_even = 1'b1; out_en = 1'b1; sleep = 1'b0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_flow_basic();
      t_pipe_basic();
      t_b2b_flow();
      t_b2b_pipe();
      t_forward();
      t_bytes();
      t_deselect();
      t_hold();
      t_oe();
      t_sleep();
      t_parity();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule